// File: doc/BRIEF.md
# Warning Sign Lamp Sequencer

This block runs a five-lamp roadside warning sign through a repeating build-up pattern. While the operate switch is on, the sign goes from fully dark to the first lamp pair, then adds the second pair, then adds the final single lamp, and then goes dark again. The pattern repeats for as long as the switch stays on. When the switch is off, the sign is held dark.

The block holds a two-bit phase register. The three lamp-group drives are decoded from that register alone, so they are Moore outputs. The next phase depends on the current phase, the operate switch and a step-enable strobe. The strobe lets a slow tick pace the pattern. When the strobe is tied high, the sign moves one phase per clock. Switching off clears the sign to dark whether or not the strobe is high.

Top module: `warnsign_seq`

## Requirements
- R1: When `rst_i` is high at a rising clock edge, the phase becomes dark (code 00) and all three lamp outputs read 0 after that edge.
- R2: With `switch_on_i` and `step_en_i` both high at an edge, the phase advances one step. The phase codes follow the order 00, 01, 10, 11 and wrap from 11 back to 00. The bench follows this order for two full laps.
- R3: The lamp outputs, given as {front, mid, tip}, are a function of the phase alone: 00 gives 000, 01 gives 100, 10 gives 110 and 11 gives 111. `lamp_front_o` drives lamps 1 and 2, `lamp_mid_o` drives lamps 3 and 4, and `lamp_tip_o` drives lamp 5.
- R4: When `switch_on_i` is low at an edge, the next phase is 00 from any phase, with `step_en_i` either high or low.
- R5: When `switch_on_i` is high and `step_en_i` is low at an edge, the phase and all lamp outputs stay unchanged.
- R6: After the switch turns on while the phase is 00, the first enabled edge moves the phase to 01. No extra dark step is inserted.
- R7: Reset takes priority over the switch and the strobe. With `rst_i` high, the phase goes to 00 even when the switch and the strobe are both high.
- R8: The lamp groups light in order: `lamp_tip_o` high implies `lamp_mid_o` high, and `lamp_mid_o` high implies `lamp_front_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; every phase change happens on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| switch_on_i | input | 1 | Operate switch; low holds the sign dark |
| step_en_i | input | 1 | Step strobe; high lets the pattern advance at the edge |
| lamp_front_o | output | 1 | Drive for lamps 1 and 2 |
| lamp_mid_o | output | 1 | Drive for lamps 3 and 4 |
| lamp_tip_o | output | 1 | Drive for lamp 5 |

## Verification
Every input takes effect at the first rising edge that samples it. The lamp outputs are decoded combinationally from the phase register, so they reflect that edge right after it, with no extra pipeline cycle. The bench changes inputs on the falling edge and compares the lamps 2 ns after the next rising edge, against a phase model it updates once per edge. This gives exactly one register of latency between stimulus and check for reset, switch-off, hold and advance alike.

// File: rtl/warnsign_pkg.sv
package warnsign_pkg;
  localparam int unsigned PHASE_W = 2;
  localparam int unsigned LAMP_GROUPS = 3;

  typedef enum logic [PHASE_W-1:0] {
    SIGN_DARK  = 2'b00,
    SIGN_FRONT = 2'b01,
    SIGN_MID   = 2'b10,
    SIGN_FULL  = 2'b11
  } sign_phase_t;

  typedef struct packed {
    logic front;
    logic mid;
    logic tip;
  } lamp_set_t;

  function automatic sign_phase_t phase_succ(sign_phase_t p);
    sign_phase_t n;
    unique case (p)
      SIGN_DARK:  n = SIGN_FRONT;
      SIGN_FRONT: n = SIGN_MID;
      SIGN_MID:   n = SIGN_FULL;
      default:    n = SIGN_DARK;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/warnsign_phase.sv
module warnsign_phase
  import warnsign_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_i,
  input  logic        switch_on_i,
  input  logic        step_en_i,
  output sign_phase_t phase_o
);
  sign_phase_t phase_q, phase_d;
  logic [PHASE_W-1:0] phase_bits;

  always_comb begin
    if (!switch_on_i)   phase_d = SIGN_DARK;
    else if (step_en_i) phase_d = phase_succ(phase_q);
    else                phase_d = phase_q;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) phase_q <= SIGN_DARK;
    else       phase_q <= phase_d;
  end

  assign phase_o    = phase_q;
  assign phase_bits = phase_q;

  // R4: switch off clears to dark regardless of the strobe
  p_switch_off_dark_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    !switch_on_i |=> phase_bits == 2'b00);

  // R2: enabled step is a modulo-four increment
  p_advance_wrap_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (switch_on_i && step_en_i) |=> phase_bits == $past(phase_bits) + 2'd1);

  // R5: no strobe, switch on, phase held
  p_hold_no_step_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (switch_on_i && !step_en_i) |=> $stable(phase_bits));
endmodule

// File: rtl/warnsign_lamps.sv
module warnsign_lamps
  import warnsign_pkg::*;
(
  input  sign_phase_t phase_i,
  output lamp_set_t   lamps_o
);
  always_comb begin
    unique case (phase_i)
      SIGN_DARK:  lamps_o = '{front: 1'b0, mid: 1'b0, tip: 1'b0};
      SIGN_FRONT: lamps_o = '{front: 1'b1, mid: 1'b0, tip: 1'b0};
      SIGN_MID:   lamps_o = '{front: 1'b1, mid: 1'b1, tip: 1'b0};
      default:    lamps_o = '{front: 1'b1, mid: 1'b1, tip: 1'b1};
    endcase
  end
endmodule

// File: rtl/warnsign_seq.sv
module warnsign_seq
  import warnsign_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic switch_on_i,
  input  logic step_en_i,
  output logic lamp_front_o,
  output logic lamp_mid_o,
  output logic lamp_tip_o
);
  sign_phase_t phase;
  lamp_set_t   lamps;

  warnsign_phase u_phase (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .switch_on_i (switch_on_i),
    .step_en_i   (step_en_i),
    .phase_o     (phase)
  );

  warnsign_lamps u_lamps (
    .phase_i (phase),
    .lamps_o (lamps)
  );

  assign lamp_front_o = lamps.front;
  assign lamp_mid_o   = lamps.mid;
  assign lamp_tip_o   = lamps.tip;

  // R8: lamp groups light cumulatively
  p_tip_needs_mid_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    lamp_tip_o |-> lamp_mid_o);
  p_mid_needs_front_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    lamp_mid_o |-> lamp_front_o);

  // R3: dark phase shows no lamp, full phase shows every lamp
  p_dark_no_lamps_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (phase == SIGN_DARK) |-> !(lamp_front_o || lamp_mid_o || lamp_tip_o));
  p_full_all_lamps_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (phase == SIGN_FULL) |-> (lamp_front_o && lamp_mid_o && lamp_tip_o));
endmodule

// File: tb/warnsign_seq_tb.sv
`timescale 1ns/1ps
module warnsign_seq_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw  = 1'b0;
  logic en  = 1'b0;
  logic front, mid, tip;

  int checks = 0;
  int failures = 0;
  int model = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  warnsign_seq dut_i (
    .clk_i       (clk),
    .rst_i       (rst),
    .switch_on_i (sw),
    .step_en_i   (en),
    .lamp_front_o(front),
    .lamp_mid_o  (mid),
    .lamp_tip_o  (tip)
  );

  function automatic logic [2:0] lamps_for(int p);
    case (p)
      0: return 3'b000;
      1: return 3'b100;
      2: return 3'b110;
      default: return 3'b111;
    endcase
  endfunction

  task automatic check_lamps(string req);
    logic [2:0] got;
    logic [2:0] exp;
    got = {front, mid, tip};
    exp = lamps_for(model);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: lamps got %b expected %b (phase %0d)", req, got, exp, model);
    end
  endtask

  // drive on falling edge, model one edge, sample 2 ns after rising edge
  task automatic step(input logic r, input logic s, input logic e, input string req);
    @(negedge clk);
    rst = r; sw = s; en = e;
    if (r)       model = 0;
    else if (!s) model = 0;
    else if (e)  model = (model + 1) % 4;
    @(posedge clk);
    #2;
    check_lamps(req);
  endtask

  task automatic t_reset;
    step(1'b1, 1'b0, 1'b0, "R1");
    step(1'b1, 1'b0, 1'b0, "R1");
  endtask

  task automatic t_two_laps;
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 1'b1, "R2 R3");
  endtask

  task automatic t_off_each_phase;
    for (int k = 0; k < 4; k++) begin
      step(1'b0, 1'b0, 1'b1, "R4 clear");
      for (int j = 0; j < k; j++) step(1'b0, 1'b1, 1'b1, "R2 setup");
      step(1'b0, 1'b0, (k % 2) == 0, "R4 switch off");
      step(1'b0, 1'b0, 1'b1, "R4 stays dark");
    end
  endtask

  task automatic t_hold;
    step(1'b0, 1'b1, 1'b1, "R2");
    step(1'b0, 1'b1, 1'b1, "R2");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0, "R5 hold");
    step(1'b0, 1'b1, 1'b1, "R2 after hold");
    step(1'b0, 1'b0, 1'b0, "R4 off with strobe low");
    step(1'b0, 1'b1, 1'b0, "R5 hold dark");
  endtask

  task automatic t_restart;
    step(1'b0, 1'b0, 1'b1, "R6 dark");
    step(1'b0, 1'b1, 1'b1, "R6 first enabled edge");
    if (model != 1) begin failures++; $display("FAIL R6: model %0d expected 1", model); end
  endtask

  task automatic t_reset_priority;
    step(1'b0, 1'b1, 1'b1, "R2");
    step(1'b1, 1'b1, 1'b1, "R7 reset over switch");
    step(1'b0, 1'b1, 1'b1, "R7 restart after reset");
  endtask

  initial begin
    t_reset();
    t_two_laps();
    t_off_each_phase();
    t_hold();
    t_restart();
    t_reset_priority();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, got hung expected done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule